// File: doc/BRIEF.md
# APB Interrupt Aggregator

This block collects up to 64 level-sensitive interrupt lines into a single active-high, level-sensitive request. That request feeds a primary interrupt controller. Software reaches the block through a zero-wait-state APB slave port. Each function has a low 32-bit word and a high 32-bit word: enable, mask, raw status and final status. Line n, for n from 0 to 31, sits at bit n of each low word. Line 32+m sits at bit m of each high word.

A line counts as final-pending when three conditions hold together: its synchronized input is high, its enable bit is 1, and its mask bit is 0. The request output is the registered OR of all final-pending bits. The number of lines, `NUM_SRC`, is a build parameter from 2 to 64. Lines at or above that count have no enable or mask storage, so they always read back as zero. Software can therefore write all ones to the enable words and count the bits that stick.

A small bus-phase state machine follows the APB transfer. It has three states:
- `PH_IDLE`: no transfer seen in the previous cycle.
- `PH_SETUP`: the previous cycle was a setup phase.
- `PH_ACCESS`: the previous cycle was an access phase.

Its transitions, taken at every clock edge, depend only on `psel` and `penable`:
- `psel` high with `penable` low goes to `PH_SETUP`.
- `psel` and `penable` both high go to `PH_ACCESS`.
- `psel` low goes to `PH_IDLE`.

A write commits only in an access cycle that directly follows a setup cycle, that is, when the machine is in `PH_SETUP`.

Top module: `apb_irq_aggregator`

## Requirements
- R1: After reset every enable and mask bit reads 0 and `irq_out` is 0.
- R2: The register offsets are enable low 0x00, enable high 0x04, mask low 0x08, mask high 0x0C, raw low 0x18, raw high 0x1C, final low 0x30 and final high 0x34. Line n<32 is bit n of a low word, and line 32+m is bit m of a high word.
- R3: Enable and mask bits for lines at or above `NUM_SRC` always read 0, even after ones are written to them.
- R4: Each final status bit equals synchronized input AND enable AND NOT mask.
- R5: Writing 1 to a mask bit blocks that line from final status, and writing 0 to it releases the line again.
- R6: The raw status words return the synchronized inputs, whatever the enable and mask settings.
- R7: `irq_out` is 1 in the cycle after any final status bit is 1, and 0 in the cycle after none is 1.
- R8: Reads of unmapped offsets return 0. Writes to unmapped offsets, and to the raw and final status words, change nothing.
- R9: `pready` is always 1 and `pslverr` is always 0.
- R10: An input rising edge reaches raw status after two clock edges, and reaches `irq_out` at the third edge.
- R11: A write commits only in an access phase that directly follows a setup phase. An aborted setup phase commits nothing, and so does an access phase with no setup phase before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Bus and logic clock |
| presetn | input | 1 | Active-low asynchronous reset |
| psel | input | 1 | Slave select |
| penable | input | 1 | Access-phase strobe |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | ADDR_W | Byte address within the window |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, 0 when not selected |
| pready | output | 1 | Always 1 |
| pslverr | output | 1 | Always 0 |
| irq_src | input | NUM_SRC | Level-sensitive interrupt lines |
| irq_out | output | 1 | Combined level-high request |

## Verification
The hardest cases to reach from the ports are the lines above `NUM_SRC` and the malformed transfers.

The missing lines are reached by building the block with 40 lines, so the high words have both stored and missing bits. Writing all ones to the high words then shows exactly eight surviving bits.

The malformed transfers are a setup phase that is abandoned, and an access phase that arrives with no setup phase before it. The bench drives these sequences on purpose, then reads the enable words back to show that nothing committed.

A near-exhaustive sweep drives one line at a time. For each line it checks final status and `irq_out` twice: once with that line enabled, and once with its neighbour enabled instead.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;

    localparam int HALF_W    = 32;
    localparam int TOTAL_SRC = 64;

    localparam logic [7:0] OFS_EN_LO  = 8'h00;
    localparam logic [7:0] OFS_EN_HI  = 8'h04;
    localparam logic [7:0] OFS_MSK_LO = 8'h08;
    localparam logic [7:0] OFS_MSK_HI = 8'h0C;
    localparam logic [7:0] OFS_RAW_LO = 8'h18;
    localparam logic [7:0] OFS_RAW_HI = 8'h1C;
    localparam logic [7:0] OFS_FIN_LO = 8'h30;
    localparam logic [7:0] OFS_FIN_HI = 8'h34;

    typedef enum logic [3:0] {
        SEL_EN_LO,
        SEL_EN_HI,
        SEL_MSK_LO,
        SEL_MSK_HI,
        SEL_RAW_LO,
        SEL_RAW_HI,
        SEL_FIN_LO,
        SEL_FIN_HI,
        SEL_NONE
    } reg_sel_e;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_SETUP,
        PH_ACCESS
    } apb_phase_e;

endpackage

// File: rtl/irq_src_sync.sv
module irq_src_sync #(
    parameter int WIDTH  = 64,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);

    logic [WIDTH-1:0] stage_q [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) begin
                stage_q[s] <= '0;
            end
        end else begin
            stage_q[0] <= async_in;
            for (int s = 1; s < STAGES; s++) begin
                stage_q[s] <= stage_q[s-1];
            end
        end
    end

    assign sync_out = stage_q[STAGES-1];

endmodule

// File: rtl/irq_bit_store.sv
module irq_bit_store
    import irq_agg_pkg::*;
#(
    parameter int NUM_SRC = 64
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en_lo,
    input  logic                 wr_en_hi,
    input  logic                 wr_msk_lo,
    input  logic                 wr_msk_hi,
    input  logic [HALF_W-1:0]    wdata,
    output logic [TOTAL_SRC-1:0] enable_q,
    output logic [TOTAL_SRC-1:0] mask_q
);

    logic [1:0] en_wr_half;
    logic [1:0] msk_wr_half;

    assign en_wr_half  = {wr_en_hi, wr_en_lo};
    assign msk_wr_half = {wr_msk_hi, wr_msk_lo};

    for (genvar i = 0; i < TOTAL_SRC; i++) begin : g_bit
        localparam int HALF = i / HALF_W;
        localparam int POS  = i % HALF_W;
        if (i < NUM_SRC) begin : g_impl
            logic en_bit_q;
            logic msk_bit_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    en_bit_q  <= 1'b0;
                    msk_bit_q <= 1'b0;
                end else begin
                    if (en_wr_half[HALF]) begin
                        en_bit_q <= wdata[POS];
                    end
                    if (msk_wr_half[HALF]) begin
                        msk_bit_q <= wdata[POS];
                    end
                end
            end
            assign enable_q[i] = en_bit_q;
            assign mask_q[i]   = msk_bit_q;
        end else begin : g_absent
            assign enable_q[i] = 1'b0;
            assign mask_q[i]   = 1'b0;
        end
    end

    AST_EN_LO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en_lo |=> $stable(enable_q[HALF_W-1:0]));                 // R11
    AST_EN_HI_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en_hi |=> $stable(enable_q[TOTAL_SRC-1:HALF_W]));         // R11
    AST_MSK_LO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_msk_lo |=> $stable(mask_q[HALF_W-1:0]));                  // R11
    AST_MSK_HI_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_msk_hi |=> $stable(mask_q[TOTAL_SRC-1:HALF_W]));          // R11

endmodule

// File: rtl/irq_apb_port.sv
module irq_apb_port
    import irq_agg_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    output reg_sel_e          sel,
    output logic              wr_commit
);

    apb_phase_e phase_q;
    apb_phase_e phase_d;

    function automatic reg_sel_e decode(input logic [ADDR_W-1:0] a);
        reg_sel_e r;
        r = SEL_NONE;
        if (a[ADDR_W-1:8] == '0) begin
            unique case (a[7:0])
                OFS_EN_LO:  r = SEL_EN_LO;
                OFS_EN_HI:  r = SEL_EN_HI;
                OFS_MSK_LO: r = SEL_MSK_LO;
                OFS_MSK_HI: r = SEL_MSK_HI;
                OFS_RAW_LO: r = SEL_RAW_LO;
                OFS_RAW_HI: r = SEL_RAW_HI;
                OFS_FIN_LO: r = SEL_FIN_LO;
                OFS_FIN_HI: r = SEL_FIN_HI;
                default:    r = SEL_NONE;
            endcase
        end
        return r;
    endfunction

    always_comb begin
        unique case (phase_q)
            PH_IDLE, PH_SETUP, PH_ACCESS: begin
                if (psel && !penable) begin
                    phase_d = PH_SETUP;
                end else if (psel && penable) begin
                    phase_d = PH_ACCESS;
                end else begin
                    phase_d = PH_IDLE;
                end
            end
            default: phase_d = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
        end else begin
            phase_q <= phase_d;
        end
    end

    always_comb begin
        sel       = decode(paddr);
        wr_commit = 1'b0;
        unique case (phase_q)
            PH_SETUP:  wr_commit = psel && penable && pwrite;
            PH_IDLE:   wr_commit = 1'b0;
            PH_ACCESS: wr_commit = 1'b0;
            default:   wr_commit = 1'b0;
        endcase
    end

    AST_COMMIT_AFTER_SETUP: assert property (@(posedge clk) disable iff (!rst_n)
        wr_commit |-> $past(psel && !penable));                       // R11

endmodule

// File: rtl/apb_irq_aggregator.sv
module apb_irq_aggregator
    import irq_agg_pkg::*;
#(
    parameter int NUM_SRC     = 64,
    parameter int ADDR_W      = 12,
    parameter int SYNC_STAGES = 2
) (
    input  logic               pclk,
    input  logic               presetn,
    input  logic               psel,
    input  logic               penable,
    input  logic               pwrite,
    input  logic [ADDR_W-1:0]  paddr,
    input  logic [31:0]        pwdata,
    output logic [31:0]        prdata,
    output logic               pready,
    output logic               pslverr,
    input  logic [NUM_SRC-1:0] irq_src,
    output logic               irq_out
);

    logic [NUM_SRC-1:0]   src_sync;
    logic [TOTAL_SRC-1:0] raw_all;
    logic [TOTAL_SRC-1:0] en_all;
    logic [TOTAL_SRC-1:0] msk_all;
    logic [TOTAL_SRC-1:0] fin_all;
    reg_sel_e             sel;
    logic                 wr_commit;
    logic                 irq_q;

    irq_src_sync #(
        .WIDTH  (NUM_SRC),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk      (pclk),
        .rst_n    (presetn),
        .async_in (irq_src),
        .sync_out (src_sync)
    );

    if (NUM_SRC < TOTAL_SRC) begin : g_pad
        assign raw_all = {{(TOTAL_SRC-NUM_SRC){1'b0}}, src_sync};
    end else begin : g_full
        assign raw_all = src_sync;
    end

    irq_apb_port #(
        .ADDR_W (ADDR_W)
    ) u_port (
        .clk       (pclk),
        .rst_n     (presetn),
        .psel      (psel),
        .penable   (penable),
        .pwrite    (pwrite),
        .paddr     (paddr),
        .sel       (sel),
        .wr_commit (wr_commit)
    );

    irq_bit_store #(
        .NUM_SRC (NUM_SRC)
    ) u_store (
        .clk       (pclk),
        .rst_n     (presetn),
        .wr_en_lo  (wr_commit && (sel == SEL_EN_LO)),
        .wr_en_hi  (wr_commit && (sel == SEL_EN_HI)),
        .wr_msk_lo (wr_commit && (sel == SEL_MSK_LO)),
        .wr_msk_hi (wr_commit && (sel == SEL_MSK_HI)),
        .wdata     (pwdata),
        .enable_q  (en_all),
        .mask_q    (msk_all)
    );

    assign fin_all = raw_all & en_all & ~msk_all;

    always_ff @(posedge pclk or negedge presetn) begin
        if (!presetn) begin
            irq_q <= 1'b0;
        end else begin
            irq_q <= |fin_all;
        end
    end

    always_comb begin
        prdata = '0;
        if (psel) begin
            unique case (sel)
                SEL_EN_LO:  prdata = en_all[HALF_W-1:0];
                SEL_EN_HI:  prdata = en_all[TOTAL_SRC-1:HALF_W];
                SEL_MSK_LO: prdata = msk_all[HALF_W-1:0];
                SEL_MSK_HI: prdata = msk_all[TOTAL_SRC-1:HALF_W];
                SEL_RAW_LO: prdata = raw_all[HALF_W-1:0];
                SEL_RAW_HI: prdata = raw_all[TOTAL_SRC-1:HALF_W];
                SEL_FIN_LO: prdata = fin_all[HALF_W-1:0];
                SEL_FIN_HI: prdata = fin_all[TOTAL_SRC-1:HALF_W];
                default:    prdata = '0;
            endcase
        end
    end

    assign pready  = 1'b1;
    assign pslverr = 1'b0;
    assign irq_out = irq_q;

    AST_IRQ_RISE: assert property (@(posedge pclk) disable iff (!presetn)
        (|fin_all) |=> irq_out);                                      // R7
    AST_IRQ_FALL: assert property (@(posedge pclk) disable iff (!presetn)
        !(|fin_all) |=> !irq_out);                                    // R7
    AST_FINAL_NEEDS_RAW: assert property (@(posedge pclk) disable iff (!presetn)
        (fin_all & ~raw_all) == '0);                                  // R4
    AST_MASKED_QUIET: assert property (@(posedge pclk) disable iff (!presetn)
        (fin_all & msk_all) == '0);                                   // R5

endmodule

// File: tb/apb_irq_aggregator_bench.sv
module apb_irq_aggregator_bench;

    localparam int N = 40;

    logic        pclk = 1'b0;
    logic        presetn = 1'b0;
    logic        psel = 1'b0;
    logic        penable = 1'b0;
    logic        pwrite = 1'b0;
    logic [11:0] paddr = '0;
    logic [31:0] pwdata = '0;
    logic [31:0] prdata;
    logic        pready;
    logic        pslverr;
    logic [N-1:0] irq_src = '0;
    logic        irq_out;

    int checks = 0;
    int fails = 0;
    bit done = 0;

    always #10 pclk = ~pclk;

    apb_irq_aggregator #(.NUM_SRC(N), .ADDR_W(12), .SYNC_STAGES(2)) u_apb_irq_aggregator (
        .pclk(pclk), .presetn(presetn), .psel(psel), .penable(penable),
        .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
        .pready(pready), .pslverr(pslverr), .irq_src(irq_src), .irq_out(irq_out)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic apb_wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge pclk);
        psel = 1; penable = 0; pwrite = 1; paddr = a; pwdata = d;
        @(negedge pclk);
        penable = 1;
        @(negedge pclk);
        psel = 0; penable = 0; pwrite = 0;
    endtask

    task automatic apb_rd(input logic [11:0] a, output logic [31:0] d);
        @(negedge pclk);
        psel = 1; penable = 0; pwrite = 0; paddr = a;
        @(negedge pclk);
        penable = 1;
        #2 d = prdata;
        @(negedge pclk);
        psel = 0; penable = 0;
    endtask

    task automatic rd_chk(input string tag, input logic [11:0] a, input logic [31:0] exp);
        logic [31:0] v;
        apb_rd(a, v);
        check(tag, v, exp);
    endtask

    task automatic settle();
        repeat (4) @(negedge pclk);
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [63:0] src64, en64, msk64, fin64;
        repeat (3) @(negedge pclk);
        presetn = 1;
        @(negedge pclk);

        // R1 and R9: reset state
        check("R1 irq_out", {31'b0, irq_out}, 0);
        check("R9 pready", {31'b0, pready}, 1);
        check("R9 pslverr", {31'b0, pslverr}, 0);
        rd_chk("R1 en_lo", 12'h000, 0);
        rd_chk("R1 en_hi", 12'h004, 0);
        rd_chk("R1 msk_lo", 12'h008, 0);
        rd_chk("R1 msk_hi", 12'h00C, 0);

        // R3: only N-32 = 8 high bits exist
        apb_wr(12'h000, 32'hFFFF_FFFF);
        apb_wr(12'h004, 32'hFFFF_FFFF);
        apb_wr(12'h00C, 32'hFFFF_FFFF);
        rd_chk("R3 en_lo all", 12'h000, 32'hFFFF_FFFF);
        rd_chk("R3 en_hi probe", 12'h004, 32'h0000_00FF);
        rd_chk("R3 msk_hi probe", 12'h00C, 32'h0000_00FF);
        apb_wr(12'h000, 0);
        apb_wr(12'h004, 0);
        apb_wr(12'h00C, 0);

        // R2, R4, R7: one line at a time, own enable then neighbour enable
        for (int i = 0; i < N; i++) begin
            src64 = 64'd1 << i;
            irq_src = src64[N-1:0];
            en64 = 64'd1 << i;
            apb_wr(12'h000, en64[31:0]);
            apb_wr(12'h004, en64[63:32]);
            settle();
            fin64 = src64 & en64;
            rd_chk("R2 fin_lo sweep", 12'h030, fin64[31:0]);
            rd_chk("R2 fin_hi sweep", 12'h034, fin64[63:32]);
            check("R7 irq on", {31'b0, irq_out}, 1);
            en64 = 64'd1 << ((i + 1) % N);
            apb_wr(12'h000, en64[31:0]);
            apb_wr(12'h004, en64[63:32]);
            settle();
            rd_chk("R4 fin_lo neighbour", 12'h030, 0);
            rd_chk("R4 fin_hi neighbour", 12'h034, 0);
            check("R7 irq off", {31'b0, irq_out}, 0);
        end

        // R6: raw ignores gating
        apb_wr(12'h000, 0);
        apb_wr(12'h004, 0);
        src64 = 64'h0000_00A5_1234_5678;
        irq_src = src64[N-1:0];
        settle();
        rd_chk("R6 raw_lo", 12'h018, src64[31:0]);
        rd_chk("R6 raw_hi", 12'h01C, src64[63:32]);
        rd_chk("R4 fin_lo disabled", 12'h030, 0);

        // R5: masking and unmasking
        src64 = 64'h0000_00FF_FFFF_FFFF;
        irq_src = src64[N-1:0];
        en64 = 64'h0000_00FF_FFFF_FFFF;
        msk64 = 64'h0000_0055_AAAA_AAAA;
        apb_wr(12'h000, en64[31:0]);
        apb_wr(12'h004, en64[63:32]);
        apb_wr(12'h008, msk64[31:0]);
        apb_wr(12'h00C, msk64[63:32]);
        settle();
        fin64 = src64 & en64 & ~msk64;
        rd_chk("R5 fin_lo masked", 12'h030, fin64[31:0]);
        rd_chk("R5 fin_hi masked", 12'h034, fin64[63:32]);
        apb_wr(12'h008, 32'hFFFF_FFFF);
        apb_wr(12'h00C, 32'hFFFF_FFFF);
        settle();
        rd_chk("R5 fin_lo all masked", 12'h030, 0);
        check("R7 irq all masked", {31'b0, irq_out}, 0);
        apb_wr(12'h008, 0);
        apb_wr(12'h00C, 0);
        settle();
        rd_chk("R5 fin_lo unmasked", 12'h030, 32'hFFFF_FFFF);
        rd_chk("R5 fin_hi unmasked", 12'h034, 32'h0000_00FF);

        // R8: unmapped reads, ignored writes
        rd_chk("R8 unmapped 0x10", 12'h010, 0);
        rd_chk("R8 unmapped 0x3C", 12'h03C, 0);
        rd_chk("R8 unmapped 0x400", 12'h400, 0);
        apb_wr(12'h030, 0);
        apb_wr(12'h018, 0);
        apb_wr(12'h010, 0);
        apb_wr(12'h400, 0);
        rd_chk("R8 en_lo kept", 12'h000, 32'hFFFF_FFFF);
        rd_chk("R8 fin_lo kept", 12'h030, 32'hFFFF_FFFF);

        // R11: aborted setup and access without setup
        @(negedge pclk);
        psel = 1; penable = 0; pwrite = 1; paddr = 12'h000; pwdata = 0;
        @(negedge pclk);
        psel = 0; pwrite = 0;
        @(negedge pclk);
        psel = 1; penable = 1; pwrite = 1; paddr = 12'h000; pwdata = 0;
        @(negedge pclk);
        psel = 0; penable = 0; pwrite = 0;
        rd_chk("R11 en_lo unchanged", 12'h000, 32'hFFFF_FFFF);

        // R10: latency from input to irq_out
        irq_src = '0;
        apb_wr(12'h000, 32'h0000_0008);
        apb_wr(12'h004, 0);
        settle();
        check("R10 idle", {31'b0, irq_out}, 0);
        irq_src[3] = 1'b1;
        @(posedge pclk);
        @(posedge pclk);
        @(negedge pclk);
        check("R10 after two edges", {31'b0, irq_out}, 0);
        @(posedge pclk);
        @(negedge pclk);
        check("R10 after three edges", {31'b0, irq_out}, 1);
        check("R9 pslverr end", {31'b0, pslverr}, 0);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule